// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block drains a circular queue of 16-byte commands that software keeps in memory. Software writes commands into the ring and moves a tail pointer. Whenever fetching is enabled and the head pointer differs from the tail, the engine reads the entry at the head as two 64-bit beats. It decodes the opcode and fires a single-cycle strobe for that command type, with both command words attached. It then advances the head by one entry.

The ring geometry comes from a packed base register. The physical base is 4 KiB aligned, and a 4-bit size code selects a ring of 2^code entries. A completion-wait command stores an 8-byte value to memory before it retires. When its interrupt enable is set, it also latches a status flag and pulses an interrupt line. An opcode outside the defined set halts the ring on the offending entry and reports an illegal-command event. The ring stays halted until software rewrites the control register.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset the head offset reads 0, every status bit is 0, and no memory request, strobe, error or interrupt is active.
- R2: A fetch starts only while control bit 0 and control bit 12 are both 1. With either bit clear, no read is issued and no command retires.
- R3: The read for entry e is issued at byte address {base[51:12], 12'h000} + 16*e. The first returned beat is command word 0 (bytes 0-7) and the second is word 1 (bytes 8-15).
- R4: Head and tail hold a byte offset in bits 18:4. The ring has 2^S entries, where S is bits 59:56 of the base register. Each retired command advances the head by one entry (16 bytes), modulo the ring length.
- R5: The ring is empty when head equals tail. No read is issued while it is empty.
- R6: The opcode is word 0 bits 63:60. A legal opcode k (1 to 8) pulses cmdStb[k-1] for exactly one cycle, with cmdWord0 and cmdWord1 carrying the fetched words. At most one strobe bit is ever high.
- R7: Opcode 1 (completion wait) writes word 1 to byte address {word0[51:3], 3'b000} before its strobe fires. No other opcode uses the write port.
- R8: When control bit 4 is set, a retired completion wait pulses compIrq for one cycle and sets status bit 2. Status bit 2 stays set until a 1 is written to statusClr bit 2. With control bit 4 clear, neither effect occurs.
- R9: Opcodes 0 and 9-15 are illegal. An illegal opcode pulses errValid once with errCode 5, fires no strobe, leaves the head on that entry, and stops fetching until a ctrlWrite pulse.
- R10: Status bit 4 reads 1 exactly when control bits 0 and 12 are set and the ring is not halted by an illegal command.
- R11: A headLoad pulse loads headIn bits 18:4, masked to the ring length, into the head pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringBaseReg | input | 64 | Ring base (bits 51:12) and size code (bits 59:56) |
| tailReg | input | 64 | Software tail offset, bits 18:4 |
| ctrlReg | input | 64 | Control: bit 0 global enable, bit 4 completion interrupt enable, bit 12 ring enable |
| ctrlWrite | input | 1 | Pulse when software rewrites the control register; clears a halt |
| headLoad | input | 1 | Load the head pointer from headIn |
| headIn | input | 64 | New head offset, bits 18:4 |
| statusClr | input | 8 | Write-one-to-clear mask for status bits |
| headOut | output | 64 | Current head offset, bits 18:4 |
| statusOut | output | 8 | Bit 4 running, bit 2 completion flag |
| memRdReq | output | 1 | Read request for one 16-byte entry |
| memRdAddr | output | 52 | Byte address of the entry |
| memRdGnt | input | 1 | Read request accepted |
| memRdValid | input | 1 | Read data beat valid |
| memRdData | input | 64 | Read data beat |
| memWrReq | output | 1 | Completion-wait store request |
| memWrAddr | output | 52 | Store byte address |
| memWrData | output | 64 | Store data |
| memWrGnt | input | 1 | Store accepted |
| cmdStb | output | 8 | One-hot command strobe, bit k-1 for opcode k |
| cmdWord0 | output | 64 | Command word 0 |
| cmdWord1 | output | 64 | Command word 1 |
| errValid | output | 1 | Illegal-command event |
| errCode | output | 4 | Event code, 5 for an illegal command |
| compIrq | output | 1 | Completion-wait interrupt pulse |

## Verification
The bench walks every legal opcode through an 8-entry ring, so that the head crosses the wrap point. It then shrinks the ring to 4 entries after a software head load. A design that ignored the size code would keep walking past the wrap and fetch from the wrong addresses. A design with a swapped beat order would present the words swapped on the strobe. The bench runs completion waits with the interrupt enable off and then on. This catches a flag or interrupt that fires without the enable, and a sticky bit that does not clear. It places an illegal opcode (11, and later 0) in front of a legal entry. A design that skipped the bad entry, kept running, or resumed without a control rewrite would retire extra commands or move the head.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  localparam int NUM_OPS = 8;
  localparam logic [3:0] OP_COMP_WAIT = 4'd1;
  localparam logic [3:0] ILLEGAL_CODE = 4'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_BEAT0, ST_BEAT1, ST_DECODE, ST_WRITE, ST_RETIRE
  } fetchState_t;

  typedef struct packed {
    logic capLo;
    logic capHi;
    logic retire;
    logic halt;
    logic compDone;
  } ctrlStb_t;

  function automatic logic opLegal(input logic [3:0] op);
    return (op >= 4'd1) && (op <= 4'(NUM_OPS));
  endfunction
endpackage

// File: rtl/cmd_ring_dp.sv
module cmd_ring_dp
  import cmd_ring_pkg::*;
#(
  parameter int ADDR_W = 52,
  parameter int PTR_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [63:0]       ringBaseReg,
  input  logic [63:0]       tailReg,
  input  logic [63:0]       ctrlReg,
  input  logic              ctrlWrite,
  input  logic              headLoad,
  input  logic [63:0]       headIn,
  input  logic [7:0]        statusClr,
  input  logic [63:0]       memRdData,
  output logic [63:0]       headOut,
  output logic [7:0]        statusOut,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [63:0]       wrData,
  output logic [63:0]       word0,
  output logic [63:0]       word1,
  output logic [3:0]        opcode,
  output logic              empty,
  output logic              runOk
);
  localparam int OFS_LSB = 4;
  localparam int OFS_MSB = OFS_LSB + PTR_W - 1;

  logic [PTR_W-1:0] head, lenMask, tailIdx, headNext;
  logic [3:0] sizeCode;
  logic halted, compFlag;

  assign sizeCode = ringBaseReg[59:56];

  always_comb begin
    for (int i = 0; i < PTR_W; i++) lenMask[i] = (i < int'(sizeCode));
  end

  assign tailIdx  = tailReg[OFS_MSB:OFS_LSB] & lenMask;
  assign headNext = (head + 1'b1) & lenMask;
  assign empty    = (head == tailIdx);
  assign runOk    = ctrlReg[0] & ctrlReg[12] & ~halted;
  assign opcode   = word0[63:60];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head <= '0;
      halted <= 1'b0;
      compFlag <= 1'b0;
      word0 <= '0;
      word1 <= '0;
    end else begin
      if (headLoad) head <= headIn[OFS_MSB:OFS_LSB] & lenMask;
      else if (stb.retire) head <= headNext;
      if (stb.capLo) word0 <= memRdData;
      if (stb.capHi) word1 <= memRdData;
      if (stb.halt) halted <= 1'b1;
      else if (ctrlWrite) halted <= 1'b0;
      if (stb.compDone && ctrlReg[4]) compFlag <= 1'b1;
      else if (statusClr[2]) compFlag <= 1'b0;
    end
  end

  assign rdAddr = {ringBaseReg[ADDR_W-1:12], 12'h000} + ADDR_W'({head, 4'h0});
  assign wrAddr = {word0[ADDR_W-1:3], 3'b000};
  assign wrData = word1;
  assign headOut = 64'({head, 4'h0});
  assign statusOut = {3'b000, runOk, 1'b0, compFlag, 2'b00};

  a_r4_head_step: assert property (@(posedge clk) disable iff (!rstN)
    stb.retire && !headLoad |=> head == (($past(head) + 1'b1) & $past(lenMask)));
  a_r9_halt_holds_head: assert property (@(posedge clk) disable iff (!rstN)
    halted && !headLoad && !ctrlWrite |=> head == $past(head));
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    compFlag && !statusClr[2] |=> compFlag);
endmodule

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl
  import cmd_ring_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         runOk,
  input  logic         empty,
  input  logic [3:0]   opcode,
  input  logic         irqEn,
  input  logic         memRdGnt,
  input  logic         memRdValid,
  input  logic         memWrGnt,
  output ctrlStb_t     stb,
  output logic         memRdReq,
  output logic         memWrReq,
  output logic [NUM_OPS-1:0] cmdStb,
  output logic         errValid,
  output logic [3:0]   errCode,
  output logic         compIrq
);
  fetchState_t state, stateNext;
  logic legal;

  assign legal = opLegal(opcode);

  always_comb begin
    stateNext = state;
    stb = '0;
    memRdReq = 1'b0;
    memWrReq = 1'b0;
    cmdStb = '0;
    errValid = 1'b0;
    compIrq = 1'b0;
    case (state)
      ST_IDLE:   if (runOk && !empty) stateNext = ST_REQ;
      ST_REQ: begin
        memRdReq = 1'b1;
        if (memRdGnt) stateNext = ST_BEAT0;
      end
      ST_BEAT0: if (memRdValid) begin
        stb.capLo = 1'b1;
        stateNext = ST_BEAT1;
      end
      ST_BEAT1: if (memRdValid) begin
        stb.capHi = 1'b1;
        stateNext = ST_DECODE;
      end
      ST_DECODE: begin
        if (!legal) begin
          errValid = 1'b1;
          stb.halt = 1'b1;
          stateNext = ST_IDLE;
        end else if (opcode == OP_COMP_WAIT) stateNext = ST_WRITE;
        else stateNext = ST_RETIRE;
      end
      ST_WRITE: begin
        memWrReq = 1'b1;
        if (memWrGnt) stateNext = ST_RETIRE;
      end
      ST_RETIRE: begin
        stb.retire = 1'b1;
        cmdStb[opcode - 4'd1] = 1'b1;
        if (opcode == OP_COMP_WAIT) begin
          stb.compDone = 1'b1;
          compIrq = irqEn;
        end
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign errCode = errValid ? ILLEGAL_CODE : 4'd0;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  a_r6_onehot_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdStb));
  a_r2_fetch_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRdReq) |-> $past(runOk && !empty));
  a_r7_write_only_cw: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |-> opcode == OP_COMP_WAIT);
  a_r9_no_strobe_after_error: assert property (@(posedge clk) disable iff (!rstN)
    errValid |=> cmdStb == '0);
endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine
  import cmd_ring_pkg::*;
#(
  parameter int ADDR_W = 52,
  parameter int PTR_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [63:0]       ringBaseReg,
  input  logic [63:0]       tailReg,
  input  logic [63:0]       ctrlReg,
  input  logic              ctrlWrite,
  input  logic              headLoad,
  input  logic [63:0]       headIn,
  input  logic [7:0]        statusClr,
  output logic [63:0]       headOut,
  output logic [7:0]        statusOut,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdGnt,
  input  logic              memRdValid,
  input  logic [63:0]       memRdData,
  output logic              memWrReq,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [63:0]       memWrData,
  input  logic              memWrGnt,
  output logic [7:0]        cmdStb,
  output logic [63:0]       cmdWord0,
  output logic [63:0]       cmdWord1,
  output logic              errValid,
  output logic [3:0]        errCode,
  output logic              compIrq
);
  ctrlStb_t stb;
  logic [3:0] opcode;
  logic empty, runOk;

  cmd_ring_dp #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .ringBaseReg(ringBaseReg),
    .tailReg(tailReg), .ctrlReg(ctrlReg), .ctrlWrite(ctrlWrite),
    .headLoad(headLoad), .headIn(headIn), .statusClr(statusClr),
    .memRdData(memRdData), .headOut(headOut), .statusOut(statusOut),
    .rdAddr(memRdAddr), .wrAddr(memWrAddr), .wrData(memWrData),
    .word0(cmdWord0), .word1(cmdWord1), .opcode(opcode),
    .empty(empty), .runOk(runOk)
  );

  cmd_ring_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .runOk(runOk), .empty(empty), .opcode(opcode),
    .irqEn(ctrlReg[4]), .memRdGnt(memRdGnt), .memRdValid(memRdValid),
    .memWrGnt(memWrGnt), .stb(stb), .memRdReq(memRdReq), .memWrReq(memWrReq),
    .cmdStb(cmdStb), .errValid(errValid), .errCode(errCode), .compIrq(compIrq)
  );
endmodule

// File: tb/sim_cmd_ring_engine.sv
module sim_cmd_ring_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [63:0] ringBaseReg = '0, tailReg = '0, ctrlReg = '0, headIn = '0;
  logic ctrlWrite = 1'b0, headLoad = 1'b0;
  logic [7:0] statusClr = '0;
  logic [63:0] headOut;
  logic [7:0] statusOut;
  logic memRdReq, memWrReq;
  logic [51:0] memRdAddr, memWrAddr;
  logic memRdGnt = 1'b0, memRdValid = 1'b0, memWrGnt = 1'b0;
  logic [63:0] memRdData = '0;
  logic [63:0] memWrData, cmdWord0, cmdWord1;
  logic [7:0] cmdStb;
  logic errValid, compIrq;
  logic [3:0] errCode;

  always #10 clk = ~clk;

  cmd_ring_engine u0 (
    .clk(clk), .rstN(rstN), .ringBaseReg(ringBaseReg), .tailReg(tailReg),
    .ctrlReg(ctrlReg), .ctrlWrite(ctrlWrite), .headLoad(headLoad), .headIn(headIn),
    .statusClr(statusClr), .headOut(headOut), .statusOut(statusOut),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdGnt(memRdGnt),
    .memRdValid(memRdValid), .memRdData(memRdData), .memWrReq(memWrReq),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrGnt(memWrGnt),
    .cmdStb(cmdStb), .cmdWord0(cmdWord0), .cmdWord1(cmdWord1),
    .errValid(errValid), .errCode(errCode), .compIrq(compIrq)
  );

  logic [63:0] mem [0:63];
  int checks = 0, errors = 0;
  int nStb = 0, nRd = 0, nWr = 0, nErr = 0, nIrq = 0;
  logic [3:0]  stbOp [0:63];
  logic [63:0] stbW0 [0:63];
  logic [63:0] stbW1 [0:63];
  logic [51:0] rdA [0:63];
  logic [51:0] wrA;
  logic [63:0] wrD;
  logic [3:0]  lastErrCode;
  localparam logic [63:0] BASE = 64'h5000;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory read responder: grant, then two beats
  initial forever begin
    @(negedge clk);
    if (memRdReq) begin
      logic [51:0] a;
      a = memRdAddr;
      memRdGnt = 1'b1;
      if (nRd < 64) rdA[nRd] = a;
      nRd++;
      @(negedge clk);
      memRdGnt = 1'b0;
      memRdValid = 1'b1;
      memRdData = mem[(a >> 3) & 52'd63];
      @(negedge clk);
      memRdData = mem[((a >> 3) + 52'd1) & 52'd63];
      @(negedge clk);
      memRdValid = 1'b0;
    end
  end

  // write responder
  initial forever begin
    @(negedge clk);
    if (memWrReq && !memWrGnt) begin
      memWrGnt = 1'b1;
      wrA = memWrAddr;
      wrD = memWrData;
      nWr++;
    end else memWrGnt = 1'b0;
  end

  // output monitor
  initial forever begin
    @(negedge clk);
    if (|cmdStb && nStb < 64) begin
      for (int b = 0; b < 8; b++) if (cmdStb[b]) stbOp[nStb] = 4'(b + 1);
      stbW0[nStb] = cmdWord0;
      stbW1[nStb] = cmdWord1;
      nStb++;
    end
    if (errValid) begin nErr++; lastErrCode = errCode; end
    if (compIrq) nIrq++;
  end

  function automatic logic [63:0] mkW0(input logic [3:0] op, input int e);
    return {op, 60'h0} | 64'(32'h100 * e + 32'h11);
  endfunction

  task automatic putCmd(input int e, input logic [3:0] op);
    mem[2*e] = mkW0(op, e);
    mem[2*e+1] = 64'hA000 + 64'(e);
  endtask

  task automatic waitHead(input logic [63:0] exp);
    int n = 0;
    while (headOut !== exp && n < 3000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic expectRun(input int firstStb, input int firstRd, input int e0,
                           input int cnt, input int len, input string req);
    for (int k = 0; k < cnt; k++) begin
      int e;
      e = (e0 + k) % len;
      check({req, " opcode"}, 64'(stbOp[firstStb+k]), 64'(mem[2*e][63:60]));
      check({req, " word0"}, stbW0[firstStb+k], mem[2*e]);
      check({req, " word1"}, stbW1[firstStb+k], mem[2*e+1]);
      check("R3 read address", 64'(rdA[firstRd+k]), BASE + 64'(16 * e));
    end
  endtask

  initial begin
    int s0, r0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 head", headOut, 64'h0);
    check("R1 status", 64'(statusOut), 64'h0);
    check("R1 rdreq", 64'(memRdReq), 64'h0);
    check("R1 strobe", 64'(cmdStb), 64'h0);

    // R2 gating by both enable bits
    ringBaseReg = (64'd3 << 56) | BASE;
    putCmd(0, 4'd2); putCmd(1, 4'd3); putCmd(2, 4'd4);
    tailReg = 64'h30;
    ctrlReg = 64'h0;    repeat (30) @(negedge clk);
    ctrlReg = 64'h1;    repeat (30) @(negedge clk);
    ctrlReg = 64'h1000; repeat (30) @(negedge clk);
    check("R2 no reads when disabled", 64'(nRd), 64'h0);
    check("R2 no strobes when disabled", 64'(nStb), 64'h0);
    check("R10 status4 clear when disabled", 64'(statusOut[4]), 64'h0);

    // R4 R6 first three commands
    ctrlReg = 64'h1001;
    waitHead(64'h30);
    check("R10 status4 running", 64'(statusOut[4]), 64'h1);
    check("R4 head offset", headOut, 64'h30);
    check("R6 strobe count", 64'(nStb), 64'd3);
    check("R5 stop when empty", 64'(nRd), 64'd3);
    expectRun(0, 0, 0, 3, 8, "R6");

    // R4 wrap with remaining opcodes
    putCmd(3, 4'd5); putCmd(4, 4'd6); putCmd(5, 4'd7); putCmd(6, 4'd8);
    putCmd(7, 4'd2); putCmd(0, 4'd3); putCmd(1, 4'd4);
    tailReg = 64'h20;
    waitHead(64'h20);
    check("R4 wrapped head", headOut, 64'h20);
    check("R5 read count after wrap", 64'(nRd), 64'd10);
    expectRun(3, 3, 3, 7, 8, "R6 wrap");

    // R7 completion wait without interrupt enable
    mem[4] = {4'd1, 60'h0} | 64'h9000;
    mem[5] = 64'hD00D;
    s0 = nStb;
    tailReg = 64'h30;
    waitHead(64'h30);
    check("R7 write count", 64'(nWr), 64'd1);
    check("R7 write address", 64'(wrA), 64'h9000);
    check("R7 write data", wrD, 64'hD00D);
    check("R7 strobe op1", 64'(stbOp[s0]), 64'd1);
    check("R8 no irq when disabled", 64'(nIrq), 64'd0);
    check("R8 no flag when disabled", 64'(statusOut[2]), 64'd0);

    // R8 with interrupt enable
    ctrlReg = 64'h1011;
    mem[6] = {4'd1, 60'h0} | 64'h9108;
    mem[7] = 64'hBEEF;
    tailReg = 64'h40;
    waitHead(64'h40);
    check("R8 irq pulse count", 64'(nIrq), 64'd1);
    check("R8 status2 set", 64'(statusOut[2]), 64'd1);
    check("R7 second write address", 64'(wrA), 64'h9108);
    repeat (5) @(negedge clk);
    check("R8 status2 sticky", 64'(statusOut[2]), 64'd1);
    statusClr = 8'h04; @(negedge clk); statusClr = 8'h00; @(negedge clk);
    check("R8 status2 cleared", 64'(statusOut[2]), 64'd0);

    // R9 illegal opcode 11 then legal entry
    ctrlReg = 64'h1001;
    mem[8] = {4'hB, 60'h0} | 64'h55;
    putCmd(5, 4'd2);
    s0 = nStb;
    tailReg = 64'h60;
    repeat (60) @(negedge clk);
    check("R9 error count", 64'(nErr), 64'd1);
    check("R9 error code", 64'(lastErrCode), 64'd5);
    check("R9 head held", headOut, 64'h40);
    check("R9 no strobe", 64'(nStb - s0), 64'd0);
    check("R10 status4 clear when halted", 64'(statusOut[4]), 64'd0);
    putCmd(4, 4'd6);
    r0 = nRd;
    ctrlWrite = 1'b1; @(negedge clk); ctrlWrite = 1'b0;
    waitHead(64'h60);
    check("R9 resumed head", headOut, 64'h60);
    check("R10 status4 after rewrite", 64'(statusOut[4]), 64'd1);
    expectRun(s0, r0, 4, 2, 8, "R9 resume");

    // R11 head load and R4 size-4 ring wrap
    ctrlReg = 64'h0;
    ringBaseReg = (64'd2 << 56) | BASE;
    headIn = 64'h20; headLoad = 1'b1; @(negedge clk); headLoad = 1'b0;
    @(negedge clk);
    check("R11 head loaded", headOut, 64'h20);
    headIn = 64'h70; headLoad = 1'b1; @(negedge clk); headLoad = 1'b0;
    @(negedge clk);
    check("R11 head load masked", headOut, 64'h30);
    headIn = 64'h20; headLoad = 1'b1; @(negedge clk); headLoad = 1'b0;
    putCmd(2, 4'd6); putCmd(3, 4'd7); putCmd(0, 4'd8);
    tailReg = 64'h10;
    s0 = nStb; r0 = nRd;
    ctrlReg = 64'h1001;
    waitHead(64'h10);
    check("R4 small ring head", headOut, 64'h10);
    check("R4 small ring count", 64'(nStb - s0), 64'd3);
    expectRun(s0, r0, 2, 3, 4, "R4 small ring");

    // R9 opcode 0 is illegal
    mem[2] = 64'h77;
    s0 = nStb;
    tailReg = 64'h20;
    repeat (60) @(negedge clk);
    check("R9 opcode0 error", 64'(nErr), 64'd2);
    check("R9 opcode0 head held", headOut, 64'h10);
    check("R9 opcode0 no strobe", 64'(nStb - s0), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule